// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control word and the slot status word of a downstream port that supports hot insertion and removal. Software reaches both through a small configuration-style port: writes are accepted only as 16-bit words at either word address, and one dword read at the control address returns status in the upper half and control in the lower half. A side-band input lets the surrounding logic OR event flags into status, for example presence or a button press.

The block watches each control write. When the slot is occupied and software moves the power indicator field to "off" from any other value, the block treats this as a removal request. It clears the presence bit, raises the presence-changed bit and asserts a removal flag for the environment. Any control write that changes the stored value raises command-completed. Both cases can produce a one-cycle interrupt pulse, gated by the enables held in control and by the external message-interrupt enable.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, with the slot implemented, control reads 0x03C0 (power indicator bits 9:8 = 2'b11 and attention indicator bits 7:6 = 2'b11, both meaning off), status reads 0, and `irq_pulse` and `removal_valid` are low.
- R2: A read whose dword index equals the control address (SLOT_OFS/4) returns status in bits 31:16 and control in bits 15:0. Any other index returns 0.
- R3: A write with `wr_size` = 1 (word) at SLOT_OFS stores `wr_data` as control. A write with any other size (0 byte, 2 dword) at SLOT_OFS or SLOT_OFS+2 changes nothing.
- R4: A word write at SLOT_OFS+2 clears each status bit that is written 1 among bit 0 (button pressed), bit 1 (power fault), bit 3 (presence changed), bit 4 (command completed) and bit 8 (link state changed). Other status bits, including presence at bit 6, are unchanged.
- R5: A cycle with `flag_set_en` high ORs `flag_set` into status.
- R6: A control write whose value differs from the stored control sets status bit 4. It pulses `irq_pulse` in the next cycle if bit 4 (completion interrupt enable) of the new control is 1. A write of the same value sets nothing.
- R7: A removal event happens on a control write when status bit 6 is 1, the new bits 9:8 are 2'b11 and the old bits 9:8 are not. The event clears status bit 6, sets status bit 3 and raises `removal_valid`.
- R8: On a removal event, `irq_pulse` fires when control bit 5 (hot-plug interrupt enable) is 1 and (status AND control) has bit 0 or bit 3 set.
- R9: `irq_pulse` stays low while `msi_en` is low.
- R10: `removal_valid` drops after any write strobe that is not itself a removal event.
- R11: While `slot_implemented` is low, the control half of a read is 0 and writes to control and status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_implemented | input | 1 | Strap: slot registers are present |
| msi_en | input | 1 | Message interrupt enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | 2 | 0 byte, 1 word, 2 dword |
| wr_data | input | 16 | Write data |
| rd_dw | input | ADDR_W-2 | Dword index of the read |
| rd_data | output | 32 | Read data, combinational |
| flag_set_en | input | 1 | Side-band flag strobe |
| flag_set | input | 16 | Bits ORed into status |
| irq_pulse | output | 1 | One-cycle interrupt request |
| removal_valid | output | 1 | Removal request flag |

## Verification
Directed cases first separate a changing from a repeated control write. This shows that only a real change raises command-completed. They then separate removal with each interrupt enable on and off, and removal with and without the message enable, so each gate of the interrupt is seen alone. A repeated write with the indicator already off checks that only the off transition counts. Random runs mix control, status, side-band, wrong-size and foreign-address writes with a toggling message enable, to find ordering faults between status clears and new events.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W     = 16;
  localparam int STS_ABP   = 0;
  localparam int STS_PFD   = 1;
  localparam int STS_PDC   = 3;
  localparam int STS_CC    = 4;
  localparam int STS_PDS   = 6;
  localparam int STS_DLLSC = 8;
  localparam int CTL_ABPE  = 0;
  localparam int CTL_PDCE  = 3;
  localparam int CTL_CCIE  = 4;
  localparam int CTL_HPIE  = 5;
  localparam int CTL_AIND  = 6;
  localparam int CTL_PIND  = 8;
  localparam logic [1:0] IND_OFF = 2'b11;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } wr_size_e;

  function automatic logic [REG_W-1:0] bit_of(input int pos);
    logic [REG_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  localparam logic [REG_W-1:0] STS_W1C = bit_of(STS_ABP) | bit_of(STS_PFD) |
                                         bit_of(STS_PDC) | bit_of(STS_CC)  |
                                         bit_of(STS_DLLSC);
  localparam logic [REG_W-1:0] HP_EVT  = bit_of(CTL_ABPE) | bit_of(CTL_PDCE);
  localparam logic [REG_W-1:0] CTL_RST = ({{(REG_W-2){1'b0}}, IND_OFF} << CTL_PIND) |
                                         ({{(REG_W-2){1'b0}}, IND_OFF} << CTL_AIND);
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hp_cfg_decode.sv
module hp_cfg_decode
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SLOT_OFS = 24
) (
  input  logic              slot_impl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-3:0] rd_dw,
  output logic              ctl_wr,
  output logic              sts_wr,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(SLOT_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(SLOT_OFS + 2);
  localparam logic [ADDR_W-3:0] RD_A  = CTL_A[ADDR_W-1:2];

  logic word_ok;

  always_comb begin
    word_ok = (wr_size == SZ_WORD) && wr_en && slot_impl;
    ctl_wr  = word_ok && (wr_addr == CTL_A);
    sts_wr  = word_ok && (wr_addr == STS_A);
    rd_hit  = (rd_dw == RD_A);
  end

  always_comb begin
    a_one_target_r3: assert (!(ctl_wr && sts_wr));
  end
endmodule

// File: rtl/hp_slot_core.sv
module hp_slot_core
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_impl,
  input  logic             wr_any,
  input  logic             ctl_wr,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             sb_valid,
  input  logic [REG_W-1:0] sb_flags,
  output logic [REG_W-1:0] ctl_view,
  output logic [REG_W-1:0] sts_q,
  output logic             cc_fire,
  output logic             hp_fire,
  output logic             removal_valid
);
  logic [REG_W-1:0] ctl_q, ctl_n, sts_n;
  logic             rv_n, rem_evt, sts_en, rv_en;

  always_comb begin
    ctl_n   = ctl_q;
    sts_n   = sts_q;
    rv_n    = removal_valid;
    rem_evt = 1'b0;
    cc_fire = 1'b0;
    hp_fire = 1'b0;
    if (wr_any) rv_n = 1'b0;
    if (ctl_wr) begin
      ctl_n = wdata;
      if (sts_q[STS_PDS] && (wdata[CTL_PIND+:2] == IND_OFF) &&
          (ctl_q[CTL_PIND+:2] != IND_OFF)) begin
        rem_evt        = 1'b1;
        sts_n[STS_PDS] = 1'b0;
        sts_n[STS_PDC] = 1'b1;
        rv_n           = 1'b1;
      end
      if (wdata != ctl_q) begin
        sts_n[STS_CC] = 1'b1;
        cc_fire       = wdata[CTL_CCIE];
      end
      if (rem_evt) hp_fire = wdata[CTL_HPIE] && (|(sts_n & wdata & HP_EVT));
    end
    if (sts_wr) sts_n = sts_q & ~(wdata & STS_W1C);
    if (sb_valid) sts_n = sts_n | sb_flags;
  end

  always_comb begin
    sts_en   = ctl_wr || sts_wr || sb_valid;
    rv_en    = wr_any;
    ctl_view = slot_impl ? ctl_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_wr) ctl_q <= ctl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     removal_valid <= 1'b0;
    else if (rv_en) removal_valid <= rv_n;
  end

  p_cc_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wdata != ctl_q)) |=> sts_q[STS_CC]);
  p_removal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_evt && !sb_valid) |=> (!sts_q[STS_PDS] && sts_q[STS_PDC] && removal_valid));
  p_rv_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(removal_valid) |-> $past(ctl_wr));
  p_rv_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !rem_evt) |=> !removal_valid);
  p_unimpl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_impl && !sb_valid) |=> ($stable(sts_q) && $stable(ctl_q)));
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic msi_en,
  input  logic cc_fire,
  input  logic hp_fire,
  output logic irq_pulse
);
  logic irq_n;

  always_comb begin
    irq_n = msi_en && (cc_fire || hp_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= irq_n;
  end

  p_irq_msi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msi_en));
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(cc_fire || hp_fire));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SLOT_OFS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_implemented,
  input  logic              msi_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-3:0] rd_dw,
  output logic [31:0]       rd_data,
  input  logic              flag_set_en,
  input  logic [15:0]       flag_set,
  output logic              irq_pulse,
  output logic              removal_valid
);
  logic             rst_i_n, ctl_wr, sts_wr, rd_hit, cc_fire, hp_fire;
  logic [REG_W-1:0] ctl_view, sts_q;

  hp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  hp_cfg_decode #(.ADDR_W(ADDR_W), .SLOT_OFS(SLOT_OFS)) u_dec (
    .slot_impl(slot_implemented), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .rd_dw(rd_dw), .ctl_wr(ctl_wr), .sts_wr(sts_wr),
    .rd_hit(rd_hit));

  hp_slot_core u_core (
    .clk(clk), .rst_n(rst_i_n), .slot_impl(slot_implemented), .wr_any(wr_en),
    .ctl_wr(ctl_wr), .sts_wr(sts_wr), .wdata(wr_data), .sb_valid(flag_set_en),
    .sb_flags(flag_set), .ctl_view(ctl_view), .sts_q(sts_q), .cc_fire(cc_fire),
    .hp_fire(hp_fire), .removal_valid(removal_valid));

  hp_irq_gen u_irq (
    .clk(clk), .rst_n(rst_i_n), .msi_en(msi_en), .cc_fire(cc_fire),
    .hp_fire(hp_fire), .irq_pulse(irq_pulse));

  always_comb begin
    rd_data = rd_hit ? {sts_q, ctl_view} : 32'h0;
  end

  p_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_hit |-> (rd_data == 32'h0));
endmodule

// File: tb/sim_hp_slot_regs.sv
module sim_hp_slot_regs;
  localparam int ADDR_W = 12;
  localparam int OFS    = 24;
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(OFS + 2);

  logic clk = 1'b0, rst_n = 1'b0, slot_implemented = 1'b1, msi_en = 1'b0;
  logic wr_en = 1'b0, flag_set_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [1:0] wr_size = 2'd0;
  logic [15:0] wr_data = '0, flag_set = '0;
  logic [ADDR_W-3:0] rd_dw = CTL_A[ADDR_W-1:2];
  logic [31:0] rd_data;
  logic irq_pulse, removal_valid;

  int n_chk = 0, n_err = 0;
  logic [15:0] m_ctl, m_sts;
  logic m_rv, m_irq;

  always #10 clk = ~clk;

  hp_slot_regs #(.ADDR_W(ADDR_W), .SLOT_OFS(OFS)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_implemented(slot_implemented), .msi_en(msi_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .rd_dw(rd_dw), .rd_data(rd_data), .flag_set_en(flag_set_en),
    .flag_set(flag_set), .irq_pulse(irq_pulse), .removal_valid(removal_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {m_sts, slot_implemented ? m_ctl : 16'h0};
  endfunction

  task automatic model_wr(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                          input logic [15:0] d);
    logic rem, hp, cc;
    m_rv = 1'b0; m_irq = 1'b0; hp = 1'b0; cc = 1'b0;
    if (slot_implemented && s == 2'd1 && a == CTL_A) begin
      rem = m_sts[6] && d[9:8] == 2'b11 && m_ctl[9:8] != 2'b11;
      if (rem) begin
        m_sts[6] = 1'b0; m_sts[3] = 1'b1; m_rv = 1'b1;
        hp = d[5] && ((m_sts & d & 16'h0009) != 0);
      end
      if (d != m_ctl) begin m_sts[4] = 1'b1; cc = d[4]; end
      m_ctl = d;
    end
    if (slot_implemented && s == 2'd1 && a == STS_A) m_sts = m_sts & ~(d & 16'h011B);
    m_irq = msi_en && (hp || cc);
  endtask

  task automatic do_wr(input string tag, input logic [ADDR_W-1:0] a,
                       input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
    model_wr(a, s, d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " rd"}, rd_data, exp_rd());
    chk({tag, " irq"}, {31'h0, irq_pulse}, {31'h0, m_irq});
    chk({tag, " removal_valid"}, {31'h0, removal_valid}, {31'h0, m_rv});
  endtask

  task automatic do_sb(input string tag, input logic [15:0] f);
    flag_set_en = 1'b1; flag_set = f;
    m_sts = m_sts | f;
    @(posedge clk); @(negedge clk);
    flag_set_en = 1'b0;
    chk({tag, " rd"}, rd_data, exp_rd());
    chk({tag, " irq"}, {31'h0, irq_pulse}, 32'h0);
  endtask

  initial begin
    #4000000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctl = 16'h03C0; m_sts = 16'h0; m_rv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset rd", rd_data, 32'h0000_03C0);
    chk("R1 reset irq", {31'h0, irq_pulse}, 32'h0);
    chk("R1 reset removal_valid", {31'h0, removal_valid}, 32'h0);
    // R2 foreign index reads zero
    rd_dw = CTL_A[ADDR_W-1:2] + 1'b1; #1;
    chk("R2 other index", rd_data, 32'h0);
    rd_dw = CTL_A[ADDR_W-1:2]; #1;
    // R6 same value: no completion
    do_wr("R6 same value", CTL_A, 2'd1, 16'h03C0);
    chk("R6 no cc", {31'h0, rd_data[20]}, 32'h0);
    msi_en = 1'b1;
    do_wr("R6 change ccie", CTL_A, 2'd1, 16'h0010);
    chk("R6 irq set", {31'h0, irq_pulse}, 32'h1);
    // R3 wrong sizes dropped
    do_wr("R3 byte", CTL_A, 2'd0, 16'h0123);
    do_wr("R3 dword", STS_A, 2'd2, 16'hFFFF);
    chk("R3 ctl kept", {16'h0, rd_data[15:0]}, 32'h0010);
    // R5 side-band sets presence
    do_sb("R5 set pds", 16'h0040);
    chk("R5 pds", {31'h0, rd_data[22]}, 32'h1);
    // R4 W1C leaves presence
    do_wr("R4 clear all", STS_A, 2'd1, 16'hFFFF);
    chk("R4 status", {16'h0, rd_data[31:16]}, 32'h0040);
    // R7 R8 removal with hot-plug interrupt
    do_wr("R7 removal", CTL_A, 2'd1, 16'h0328);
    chk("R7 removal_valid", {31'h0, removal_valid}, 32'h1);
    chk("R7 status", {16'h0, rd_data[31:16]}, 32'h0018);
    chk("R8 irq", {31'h0, irq_pulse}, 32'h1);
    // R10 next write drops the flag
    do_wr("R10 clear", STS_A, 2'd1, 16'h0018);
    chk("R10 removal_valid", {31'h0, removal_valid}, 32'h0);
    // R7 indicator already off: no event
    do_sb("R7 re-present", 16'h0040);
    do_wr("R7 already off", CTL_A, 2'd1, 16'h0308);
    chk("R7 no event", {31'h0, removal_valid}, 32'h0);
    // R8 removal with hot-plug enable clear: no pulse
    do_wr("R8 pic on", CTL_A, 2'd1, 16'h0008);
    do_wr("R8 removal no hpie", CTL_A, 2'd1, 16'h0308);
    chk("R8 no irq", {31'h0, irq_pulse}, 32'h0);
    chk("R8 removal_valid", {31'h0, removal_valid}, 32'h1);
    // R9 message enable low
    msi_en = 1'b0;
    do_wr("R9 change ccie", CTL_A, 2'd1, 16'h0330);
    chk("R9 no irq", {31'h0, irq_pulse}, 32'h0);
    // R11 unimplemented slot
    slot_implemented = 1'b0;
    do_wr("R11 ctl ignored", CTL_A, 2'd1, 16'h0000);
    chk("R11 ctl zero", {16'h0, rd_data[15:0]}, 32'h0);
    do_wr("R11 sts ignored", STS_A, 2'd1, 16'hFFFF);
    slot_implemented = 1'b1; #1;
    chk("R11 ctl kept", {16'h0, rd_data[15:0]}, 32'h0330);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic [15:0] d;
      op = $urandom_range(0, 9);
      msi_en = ($urandom_range(0, 3) != 0);
      d = 16'($urandom());
      if (op < 4) begin
        if ($urandom_range(0, 1) == 1) d[9:8] = 2'b11;
        do_wr("R6 R7 R8 rand ctl", CTL_A, 2'd1, d);
      end else if (op < 6) do_wr("R4 rand sts", STS_A, 2'd1, d);
      else if (op < 8) do_sb("R5 rand sb", d & 16'h015B);
      else if (op == 8) do_wr("R3 rand size", ($urandom_range(0, 1) == 1) ? CTL_A : STS_A,
                              ($urandom_range(0, 1) == 1) ? 2'd0 : 2'd2, d);
      else do_wr("R10 rand other", CTL_A + 12'd4, 2'd1, d);
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule